// File: doc/BRIEF.md
# Handshake Value Breakpoint Monitor

This block watches one link that uses a valid/accept handshake. It raises a debug event when a chosen data value crosses that link. A transfer counts only in a cycle where the sender asserts valid and the receiver asserts accept, and the data word equals the programmed match value. On the first such transfer the monitor does two things: it drives a one-cycle pulse toward the chip's event distribution network, and it sets a sticky status bit that debug software can poll.

All configuration sits in one control word of DATA_W+2 bits, loaded and read back through a plain parallel port:
- bits DATA_W-1..0 hold the match value;
- bit DATA_W is the sticky triggered flag;
- bit DATA_W+1 is the enable.

Software re-arms the monitor by writing the word with the triggered flag at zero. With the enable at zero, the link is ignored completely.

Top module: `link_bkpt_mon`

## Requirements
- R1: After reset, `cfg_rdata` reads all zeros and `dbg_event` is low.
- R2: A cycle with `cfg_load` high stores `cfg_wdata`, and from the next cycle `cfg_rdata` returns exactly that word. The fields are: match value in bits DATA_W-1..0, triggered in bit DATA_W, enable in bit DATA_W+1.
- R3: A transfer is considered only in a cycle where `lnk_valid` and `lnk_accept` are both high and `lnk_data` equals the stored match value. Valid alone, accept alone, or a different value never triggers.
- R4: A qualifying transfer while enabled and not yet triggered has two results, both visible from the clock edge that ends the transfer cycle: `dbg_event` is high for exactly one cycle, and the triggered bit reads 1 in that same cycle.
- R5: The triggered bit is sticky. Further matches do not clear it and raise no further event until software clears the bit.
- R6: Loading a word with triggered=0 clears the status and re-arms the monitor, so the next match fires again.
- R7: With the enable bit at 0, matching transfers raise no event and leave the triggered bit at 0.
- R8: When a load and a transfer fall in the same cycle, the transfer is judged against the contents held before the load. If it fires, the event is issued and the triggered bit ends at 1 even when the written word had it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lnk_valid | input | 1 | Valid of the observed link |
| lnk_accept | input | 1 | Accept of the observed link |
| lnk_data | input | DATA_W | Data of the observed link |
| cfg_load | input | 1 | Loads `cfg_wdata` into the control word |
| cfg_wdata | input | DATA_W+2 | Control word to load |
| cfg_rdata | output | DATA_W+2 | Current control word |
| dbg_event | output | 1 | One-cycle breakpoint event |

## Verification
Two functions can fall in the same cycle: a software load of the control word and a matching transfer on the link.

The bench provokes this in two ways, both with `cfg_load` asserted in the very cycle that a matching handshake completes:
- With the monitor armed, the monitor must still fire. The bench expects the pulse and a triggered bit of 1, even though the written word carried 0.
- With the monitor already triggered, the clearing write must win and no pulse may appear.

Both outcomes are judged one cycle later, at `dbg_event` and `cfg_rdata`.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  // Status/enable flags of the control word (upper two bits).
  typedef struct packed {
    logic enable;
    logic trig;
  } lbm_flags_t;
  localparam int unsigned LBM_FLAG_W = 2;
endpackage

// File: rtl/lbm_rst_sync.sv
module lbm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lbm_match.sv
module lbm_match
  import lbm_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              valid,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] match_val,
  input  lbm_flags_t        flags,
  output logic              fire
);
  logic xfer;
  logic equal;

  always_comb begin
    xfer  = valid & accept;
    equal = (data == match_val);
    fire  = xfer & equal & flags.enable & ~flags.trig;
  end
endmodule

// File: rtl/lbm_ctrl_reg.sv
module lbm_ctrl_reg
  import lbm_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned WORD_W = DATA_W + LBM_FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fire,
  output logic [DATA_W-1:0] match_val,
  output lbm_flags_t        flags,
  output logic [WORD_W-1:0] rdata
);
  logic [DATA_W-1:0] val_q, val_d;
  lbm_flags_t        flg_q, flg_d;
  logic              val_en, flg_en;

  // Next state: a firing match always sets the trig flag, even over a clearing write.
  always_comb begin
    val_en       = load;
    flg_en       = load | fire;
    val_d        = wdata[DATA_W-1:0];
    flg_d.enable = load ? wdata[DATA_W+1] : flg_q.enable;
    flg_d.trig   = (load ? wdata[DATA_W] : flg_q.trig) | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q <= '0;
    else if (flg_en) flg_q <= flg_d;
  end

  assign match_val = val_q;
  assign flags     = flg_q;
  assign rdata     = {flg_q.enable, flg_q.trig, val_q};
endmodule

// File: rtl/lbm_event.sv
module lbm_event (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic evt
);
  logic evt_q, evt_d;

  always_comb evt_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign evt = evt_q;
endmodule

// File: rtl/link_bkpt_mon.sv
module link_bkpt_mon
  import lbm_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned WORD_W = DATA_W + LBM_FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lnk_valid,
  input  logic              lnk_accept,
  input  logic [DATA_W-1:0] lnk_data,
  input  logic              cfg_load,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              dbg_event
);
  logic              rst_q_n;
  logic              fire;
  logic [DATA_W-1:0] match_val;
  lbm_flags_t        flags;

  lbm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_q_n)
  );

  lbm_match #(.DATA_W(DATA_W)) u_match (
    .valid(lnk_valid), .accept(lnk_accept), .data(lnk_data),
    .match_val(match_val), .flags(flags), .fire(fire)
  );

  lbm_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_q_n), .load(cfg_load), .wdata(cfg_wdata),
    .fire(fire), .match_val(match_val), .flags(flags), .rdata(cfg_rdata)
  );

  lbm_event u_evt (
    .clk(clk), .rst_n(rst_q_n), .fire(fire), .evt(dbg_event)
  );
endmodule

// File: rtl/link_bkpt_mon_chk.sv
module link_bkpt_mon_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lnk_valid,
  input logic              lnk_accept,
  input logic              cfg_load,
  input logic [DATA_W+1:0] cfg_rdata,
  input logic              dbg_event
);
  p_event_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |=> !dbg_event);

  p_event_sets_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> cfg_rdata[DATA_W]);

  p_trig_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[DATA_W] && !cfg_load) |=> cfg_rdata[DATA_W]);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[DATA_W+1] |=> !dbg_event);

  p_need_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lnk_valid && lnk_accept) |=> !dbg_event);
endmodule

bind link_bkpt_mon link_bkpt_mon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .lnk_valid(lnk_valid), .lnk_accept(lnk_accept),
  .cfg_load(cfg_load), .cfg_rdata(cfg_rdata), .dbg_event(dbg_event)
);

// File: tb/test_link_bkpt_mon.sv
`timescale 1ns/1ps
module test_link_bkpt_mon;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] BP = 16'd378;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lnk_valid = 1'b0, lnk_accept = 1'b0, cfg_load = 1'b0;
  logic [W-1:0] lnk_data = '0;
  logic [W+1:0] cfg_wdata = '0;
  logic [W+1:0] cfg_rdata;
  logic dbg_event;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  link_bkpt_mon #(.DATA_W(W)) i_link_bkpt_mon (.*);

  // {valid, accept, exp_event, exp_trig, data}
  localparam int NV = 7;
  localparam logic [W+3:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, BP},
    {1'b0, 1'b1, 1'b0, 1'b0, BP},
    {1'b1, 1'b1, 1'b0, 1'b0, BP - 16'd1},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b1, 1'b1, 1'b1, BP},
    {1'b1, 1'b1, 1'b0, 1'b1, BP},
    {1'b0, 1'b0, 1'b0, 1'b1, BP}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic a, input logic [W-1:0] d,
                       input logic ld, input logic [W+1:0] wd);
    lnk_valid = v; lnk_accept = a; lnk_data = d; cfg_load = ld; cfg_wdata = wd;
    cyc();
    lnk_valid = 1'b0; lnk_accept = 1'b0; cfg_load = 1'b0;
  endtask

  function automatic logic [W+1:0] word(input logic en, input logic tr, input logic [W-1:0] v);
    return {en, tr, v};
  endfunction

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", 32'(cfg_rdata), 0);
    chk("R1 event", 32'(dbg_event), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdata after release", 32'(cfg_rdata), 0);

    drive(0, 0, '0, 1, word(1, 0, BP));
    chk("R2 readback", 32'(cfg_rdata), 32'(word(1, 0, BP)));

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][W+3], VEC[i][W+2], VEC[i][W-1:0], 0, '0);
      chk(i == 4 ? "R4 event" : (i > 4 ? "R5 event" : "R3 event"),
          32'(dbg_event), 32'(VEC[i][W+1]));
      chk(i >= 4 ? "R5 trig" : "R3 trig", 32'(cfg_rdata[W]), 32'(VEC[i][W]));
    end

    // R6: clear and re-arm
    drive(0, 0, '0, 1, word(1, 0, BP));
    chk("R6 cleared", 32'(cfg_rdata[W]), 0);
    drive(1, 1, BP, 0, '0);
    chk("R6 refire event", 32'(dbg_event), 1);
    cyc();
    chk("R4 pulse one cycle", 32'(dbg_event), 0);

    // R7: disabled
    drive(0, 0, '0, 1, word(0, 0, BP));
    drive(1, 1, BP, 0, '0);
    chk("R7 no event", 32'(dbg_event), 0);
    chk("R7 no trig", 32'(cfg_rdata[W]), 0);

    // R2/R3: new value replaces old
    drive(0, 0, '0, 1, word(1, 0, 16'hBEEF));
    chk("R2 readback new", 32'(cfg_rdata), 32'(word(1, 0, 16'hBEEF)));
    drive(1, 1, BP, 0, '0);
    chk("R3 old value ignored", 32'(dbg_event), 0);

    // R8: load and firing match in same cycle
    drive(1, 1, 16'hBEEF, 1, word(1, 0, 16'h1234));
    chk("R8 event on collision", 32'(dbg_event), 1);
    chk("R8 trig kept", 32'(cfg_rdata), 32'(word(1, 1, 16'h1234)));

    // R8: clearing write while already triggered, match in same cycle
    drive(1, 1, 16'h1234, 1, word(1, 0, 16'h1234));
    chk("R8 no event when already hit", 32'(dbg_event), 0);
    chk("R8 clear wins", 32'(cfg_rdata[W]), 0);
    drive(1, 1, 16'h1234, 0, '0);
    chk("R6 fires after clear", 32'(dbg_event), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule